// File: doc/BRIEF.md
# Square-Root-Free Correlation Peak Tracker

This block takes one result per search position from an external correlation engine and keeps the position with the highest normalized cross-correlation seen so far. Each result carries two sums: the template-times-image sum (signed) and the image-squared sum (unsigned). The block never divides and never takes a square root. It compares two positions by multiplying each squared numerator by the other position's denominator and comparing the two products.

The block also decides which positions are visited. After `start` it presents a 3×3 grid of positions around the given centre, one position at a time. When the engine returns the sums for the presented position, the block moves to the next one. After nine positions the winning position becomes the new centre and the grid spacing halves: 1, 1/2, 1/4 and then 1/8 pixel. Positions are signed fixed-point numbers with three fractional bits. When the final position of the finest grid has been answered, `done` rises and stays high until the next `start`.

Top module: `ncc_peak_tracker`

## Requirements
- R1: After reset, `pos_valid`, `done`, `best_x`, `best_y`, `best_pi` and `best_ii` are all zero.
- R2: The cycle after `start` is sampled high, `pos_valid` is 1, `done` is 0, and the presented position is (start_x − 8, start_y − 8), in units of 1/8 pixel.
- R3: Within a grid the column index runs fastest and the row index slowest, each taking the values 0, 1, 2. The presented position is (cx + (col−1)·step, cy + (row−1)·step). The position advances by one after each accepted `sum_valid`.
- R4: The first result accepted after `start` always becomes the best, whatever its sums.
- R5: A later result replaces the best only when sum_pi² · best_ii > best_pi² · sum_ii holds strictly. On an exact tie the earlier position is kept.
- R6: When a result wins, `best_x` and `best_y` take the presented position, and `best_pi` and `best_ii` take its sums, in the cycle after the result.
- R7: After the ninth result of a grid, the next grid is centred on the current best. Its step is half the previous one. The steps are 8, 4, 2 and 1 in 1/8-pixel units.
- R8: After the 36th result, `done` is 1 and `pos_valid` is 0. Both hold until the next `start`.
- R9: While no search is running, `sum_valid` has no effect: the best registers keep their values.
- R10: When `start` and `sum_valid` are high in the same cycle, the start wins. The sum is discarded, the best registers are unchanged, and the new search begins at its first position.
- R11: Products are formed at full width (3 × 32 bits), so a comparison that depends on bits above bit 63 is decided correctly. This includes sum_pi = −2³¹.
- R12: A result with sum_pi = 0 never wins, unless it is the first result of a search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search around start_x/start_y |
| start_x | input | 16 | Initial centre x, signed, 3 fractional bits |
| start_y | input | 16 | Initial centre y, signed, 3 fractional bits |
| pos_valid | output | 1 | A position is presented and waits for its sums |
| pos_x | output | 16 | Presented position x |
| pos_y | output | 16 | Presented position y |
| sum_valid | input | 1 | Sums for the presented position are valid |
| sum_pi | input | 32 | Template-times-image sum, signed |
| sum_ii | input | 32 | Image-squared sum, unsigned |
| best_x | output | 16 | Best position x |
| best_y | output | 16 | Best position y |
| best_pi | output | 32 | Template-times-image sum of the best position |
| best_ii | output | 32 | Image-squared sum of the best position |
| done | output | 1 | All four grids have been answered |

## Verification
Two functions can fall in the same cycle: restarting the sequencer and accepting a result into the best registers. The bench raises `start` together with a `sum_valid` whose sums would clearly beat the current best. In the following cycle it checks three things: the best registers still hold their previous values, the presented position is the first grid point of the new centre, and the next result is accepted unconditionally as the first of the new search.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    // Position of a grid point relative to the centre, along one axis
    typedef enum logic [1:0] {
        OFS_NEG  = 2'd0,
        OFS_ZERO = 2'd1,
        OFS_POS  = 2'd2
    } grid_ofs_e;

    function automatic grid_ofs_e ofs_next(input grid_ofs_e cur);
        case (cur)
            OFS_NEG:  return OFS_ZERO;
            OFS_ZERO: return OFS_POS;
            default:  return OFS_NEG;
        endcase
    endfunction

endpackage

// File: rtl/ncc_cross_cmp.sv
module ncc_cross_cmp #(
    parameter int SUM_W = 32
) (
    input  logic signed [SUM_W-1:0] cand_pi,
    input  logic        [SUM_W-1:0] cand_ii,
    input  logic signed [SUM_W-1:0] best_pi,
    input  logic        [SUM_W-1:0] best_ii,
    output logic                    win
);
    localparam int SQ_W   = 2 * SUM_W;
    localparam int PROD_W = 3 * SUM_W;

    logic [SUM_W-1:0]  cand_mag, best_mag;
    logic [SQ_W-1:0]   cand_sq, best_sq;
    logic [PROD_W-1:0] lhs, rhs;

    // The magnitude of the most negative value is still correct when read as unsigned
    assign cand_mag = cand_pi[SUM_W-1] ? (~cand_pi + 1'b1) : cand_pi;
    assign best_mag = best_pi[SUM_W-1] ? (~best_pi + 1'b1) : best_pi;

    assign cand_sq = SQ_W'(cand_mag) * SQ_W'(cand_mag);
    assign best_sq = SQ_W'(best_mag) * SQ_W'(best_mag);

    assign lhs = PROD_W'(cand_sq) * PROD_W'(best_ii);
    assign rhs = PROD_W'(best_sq) * PROD_W'(cand_ii);

    assign win = lhs > rhs;

    always_comb begin
        if (cand_pi == '0) begin
            AST_ZERO_NUM_LOSES: assert (!win); // R12
        end
    end

endmodule

// File: rtl/ncc_grid_gen.sv
module ncc_grid_gen
    import ncc_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int FRAC_W = 3,
    parameter int STEP_W = 2
) (
    input  logic signed [POS_W-1:0] ctr_x,
    input  logic signed [POS_W-1:0] ctr_y,
    input  grid_ofs_e               col,
    input  grid_ofs_e               row,
    input  logic [STEP_W-1:0]       step_idx,
    output logic signed [POS_W-1:0] pt_x,
    output logic signed [POS_W-1:0] pt_y
);
    localparam logic [POS_W-1:0] UNIT = POS_W'(1) << FRAC_W;

    logic [POS_W-1:0]        spacing;
    logic signed [POS_W-1:0] ctr [2];
    grid_ofs_e               sel [2];
    logic signed [POS_W-1:0] pt  [2];

    assign spacing = UNIT >> step_idx;
    assign ctr[0]  = ctr_x;
    assign ctr[1]  = ctr_y;
    assign sel[0]  = col;
    assign sel[1]  = row;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        always_comb begin
            case (sel[a])
                OFS_NEG: pt[a] = ctr[a] - spacing;
                OFS_POS: pt[a] = ctr[a] + spacing;
                default: pt[a] = ctr[a];
            endcase
        end
    end

    assign pt_x = pt[0];
    assign pt_y = pt[1];

endmodule

// File: rtl/ncc_peak_tracker.sv
module ncc_peak_tracker
    import ncc_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int FRAC_W    = 3,
    parameter int NUM_STEPS = 4,
    parameter int SUM_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [POS_W-1:0] start_x,
    input  logic signed [POS_W-1:0] start_y,
    output logic                    pos_valid,
    output logic signed [POS_W-1:0] pos_x,
    output logic signed [POS_W-1:0] pos_y,
    input  logic                    sum_valid,
    input  logic signed [SUM_W-1:0] sum_pi,
    input  logic        [SUM_W-1:0] sum_ii,
    output logic signed [POS_W-1:0] best_x,
    output logic signed [POS_W-1:0] best_y,
    output logic signed [SUM_W-1:0] best_pi,
    output logic        [SUM_W-1:0] best_ii,
    output logic                    done
);
    localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [POS_W-1:0]  UNIT = POS_W'(1) << FRAC_W;

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic                    first;
        logic signed [POS_W-1:0] cx;
        logic signed [POS_W-1:0] cy;
        grid_ofs_e               col;
        grid_ofs_e               row;
        logic [STEP_W-1:0]       step_idx;
        logic signed [POS_W-1:0] bx;
        logic signed [POS_W-1:0] by;
        logic signed [SUM_W-1:0] bpi;
        logic        [SUM_W-1:0] bii;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic signed [POS_W-1:0] pt_x, pt_y;
    logic                    cand_win;
    logic                    take;

    ncc_grid_gen #(
        .POS_W  (POS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_grid (
        .ctr_x    (st_q.cx),
        .ctr_y    (st_q.cy),
        .col      (st_q.col),
        .row      (st_q.row),
        .step_idx (st_q.step_idx),
        .pt_x     (pt_x),
        .pt_y     (pt_y)
    );

    ncc_cross_cmp #(
        .SUM_W (SUM_W)
    ) u_cmp (
        .cand_pi (sum_pi),
        .cand_ii (sum_ii),
        .best_pi (st_q.bpi),
        .best_ii (st_q.bii),
        .win     (cand_win)
    );

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (start) begin
            st_d.busy     = 1'b1;
            st_d.done     = 1'b0;
            st_d.first    = 1'b1;
            st_d.cx       = start_x;
            st_d.cy       = start_y;
            st_d.col      = OFS_NEG;
            st_d.row      = OFS_NEG;
            st_d.step_idx = '0;
        end else if (st_q.busy && sum_valid) begin
            take = st_q.first || cand_win;
            if (take) begin
                st_d.bx  = pt_x;
                st_d.by  = pt_y;
                st_d.bpi = sum_pi;
                st_d.bii = sum_ii;
            end
            st_d.first = 1'b0;
            if (st_q.col != OFS_POS) begin
                st_d.col = ofs_next(st_q.col);
            end else begin
                st_d.col = OFS_NEG;
                if (st_q.row != OFS_POS) begin
                    st_d.row = ofs_next(st_q.row);
                end else begin
                    st_d.row = OFS_NEG;
                    if (st_q.step_idx == LAST_STEP) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.step_idx = st_q.step_idx + 1'b1;
                        st_d.cx       = st_d.bx;
                        st_d.cy       = st_d.by;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, first: 1'b0,
                      cx: '0, cy: '0, col: OFS_NEG, row: OFS_NEG,
                      step_idx: '0, bx: '0, by: '0, bpi: '0, bii: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_valid = st_q.busy;
    assign pos_x     = pt_x;
    assign pos_y     = pt_y;
    assign best_x    = st_q.bx;
    assign best_y    = st_q.by;
    assign best_pi   = st_q.bpi;
    assign best_ii   = st_q.bii;
    assign done      = st_q.done;

    AST_FIRST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.first && sum_valid && !start)
        |=> (best_x == $past(pos_x) && best_y == $past(pos_y) && best_pi == $past(sum_pi))); // R4

    AST_DONE_NO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pos_valid); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_valid && !start) |=> ($stable(best_x) && $stable(best_y) && $stable(best_pi) && $stable(best_ii))); // R9

    AST_START_FIRST_POS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pos_valid && !done && pos_x == $past(start_x) - UNIT && pos_y == $past(start_y) - UNIT)); // R2

    AST_START_DROPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ($stable(best_x) && $stable(best_y) && $stable(best_pi))); // R10

endmodule

// File: tb/sim_ncc_peak_tracker.sv
module sim_ncc_peak_tracker;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic signed [15:0] start_x = '0;
    logic signed [15:0] start_y = '0;
    logic               sum_valid = 1'b0;
    logic signed [31:0] sum_pi = '0;
    logic        [31:0] sum_ii = '0;
    logic               pos_valid, done;
    logic signed [15:0] pos_x, pos_y, best_x, best_y;
    logic signed [31:0] best_pi;
    logic        [31:0] best_ii;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ncc_peak_tracker u0 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .start_x (start_x), .start_y (start_y),
        .pos_valid (pos_valid), .pos_x (pos_x), .pos_y (pos_y),
        .sum_valid (sum_valid), .sum_pi (sum_pi), .sum_ii (sum_ii),
        .best_x (best_x), .best_y (best_y),
        .best_pi (best_pi), .best_ii (best_ii), .done (done)
    );

    // start_x, start_y, peak_x, peak_y, final_x, final_y (1/8 pixel units)
    localparam int NV = 3;
    localparam int TBL [NV][6] = '{
        '{  0,   0,  11,  -5,  11,  -5},
        '{ 16,  16,  16,  16,  16,  16},
        '{-40,  24, -52,  31, -52,  31}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int x, input int y);
        @(negedge clk);
        start = 1'b1; start_x = 16'(x); start_y = 16'(y);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input logic signed [31:0] pi, input logic [31:0] ii);
        sum_valid = 1'b1; sum_pi = pi; sum_ii = ii;
        @(negedge clk);
        sum_valid = 1'b0;
    endtask

    task automatic run_row(input int k);
        int cx, cy, tx, ty;
        longint rbx, rby, rpi, rii;
        bit first;
        cx = TBL[k][0]; cy = TBL[k][1]; tx = TBL[k][2]; ty = TBL[k][3];
        first = 1'b1; rbx = 0; rby = 0; rpi = 0; rii = 0;
        do_start(cx, cy);
        for (int s = 0; s < 4; s++) begin
            int st;
            st = 8 >> s;
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 3; c++) begin
                    longint ex, ey, d, pi, ii;
                    ex = cx + (c - 1) * st;
                    ey = cy + (r - 1) * st;
                    // R3 position order, R7 centre/step from the previous grid
                    chk(pos_valid == 1'b1, "R3 pos_valid", pos_valid, 1);
                    chk(pos_x == ex, (s > 0) ? "R7 pos_x" : "R3 pos_x", pos_x, ex);
                    chk(pos_y == ey, (s > 0) ? "R7 pos_y" : "R3 pos_y", pos_y, ey);
                    d  = (ex - tx) * (ex - tx) + (ey - ty) * (ey - ty);
                    pi = 4000 - d;
                    ii = 100 + d;
                    if (first || (pi * pi * rii > rpi * rpi * ii)) begin
                        rbx = ex; rby = ey; rpi = pi; rii = ii;
                    end
                    first = 1'b0;
                    feed(32'(pi), 32'(ii));
                    chk(best_x == rbx && best_y == rby, "R5 best position", best_x, rbx);
                    chk(best_pi == rpi && best_ii == rii, "R6 best sums", best_pi, rpi);
                end
            end
            cx = int'(rbx); cy = int'(rby);
        end
        chk(done == 1'b1, "R8 done raised", done, 1);
        chk(pos_valid == 1'b0, "R8 pos_valid low", pos_valid, 0);
        chk(best_x == TBL[k][4], "R7 final x", best_x, TBL[k][4]);
        chk(best_y == TBL[k][5], "R7 final y", best_y, TBL[k][5]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pos_valid == 0 && done == 0, "R1 flags", {pos_valid, done}, 0);
        chk(best_x == 0 && best_y == 0, "R1 best pos", best_x, 0);
        chk(best_pi == 0 && best_ii == 0, "R1 best sums", best_pi, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 sums before any start are ignored
        feed(32'sd1000, 32'd1);
        chk(best_pi == 0 && best_x == 0, "R9 idle after reset", best_pi, 0);
        chk(pos_valid == 0, "R9 no position", pos_valid, 0);

        for (int k = 0; k < NV; k++) run_row(k);

        // R9 after done, R8 done holds
        feed(32'sh7FFFFFFF, 32'd1);
        chk(best_x == -52 && best_y == 31, "R9 ignored after done", best_x, -52);
        chk(best_pi == 4000, "R9 sums kept", best_pi, 4000);
        chk(done == 1, "R8 done holds", done, 1);

        // R2, R4, R12, R5 ties, R6
        do_start(0, 0);
        chk(pos_x == -8 && pos_y == -8 && done == 0, "R2 first position", pos_x, -8);
        feed(32'sd5, 32'd10);
        chk(best_x == -8 && best_y == -8 && best_pi == 5, "R4 first accepted", best_pi, 5);
        feed(32'sd0, 32'd1);
        chk(best_x == -8 && best_pi == 5, "R12 zero numerator", best_x, -8);
        feed(32'sd5, 32'd10);
        chk(best_x == -8 && best_y == -8, "R5 identical tie", best_x, -8);
        feed(32'sd10, 32'd40);
        chk(best_x == -8 && best_y == -8, "R5 cross tie", best_y, -8);
        feed(32'sd10, 32'd39);
        chk(best_x == 0 && best_y == 0 && best_pi == 10 && best_ii == 39, "R6 win loads", best_ii, 39);

        // R10 start collides with a strong sum
        start = 1'b1; start_x = 16'sd24; start_y = -16'sd16;
        sum_valid = 1'b1; sum_pi = 32'sd30000; sum_ii = 32'd1;
        @(negedge clk);
        start = 1'b0; sum_valid = 1'b0;
        chk(best_x == 0 && best_y == 0 && best_pi == 10, "R10 sum dropped", best_pi, 10);
        chk(pos_x == 16 && pos_y == -24 && pos_valid == 1, "R10 restart position", pos_x, 16);
        feed(32'sd1, 32'd1000);
        chk(best_x == 16 && best_y == -24 && best_pi == 1, "R10 R4 first after restart", best_pi, 1);

        // R11 comparison depends on bits above 63
        do_start(0, 0);
        feed(32'sh7FFFFFFF, 32'hFFFFFFFF);
        chk(best_pi == 32'sh7FFFFFFF, "R11 first", best_pi, 32'sh7FFFFFFF);
        feed(32'sh80000000, 32'hFFFFFFFF);
        chk(best_x == 0 && best_y == -8, "R11 wide win", best_x, 0);
        chk(best_pi == -64'sd2147483648, "R11 negative sum", best_pi, -64'sd2147483648);
        feed(32'sh7FFFFFFF, 32'hFFFFFFFF);
        chk(best_x == 0 && best_y == -8, "R11 wide loss", best_x, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule